// File: doc/BRIEF.md
# TPM SPI Register Transaction Engine

This block is an SPI master that carries out one register access to a TPM over a four-wire SPI link. A client presents a request made of a direction, a 16-bit register address, a byte count and, for writes, the payload. The engine pulls chip select low and sends a four-byte header. It then watches the device's flow-control bit and, if needed, sends zero bytes until the device is ready. It moves the payload and raises chip select again. It finishes with a one-cycle completion pulse, a status code and, for reads, the received bytes.

A chunk mode serves short reads of 1, 2 or 4 bytes, as used for status and FIFO registers. Illegal lengths are refused before anything appears on the bus. The serial clock runs in SPI mode 0 and is derived from the system clock by a parameterised divider.

Top module: `tpm_spi_seq`

## Requirements
- R1: The first byte sent in each transaction is a control byte. Bit 7 is 1 for a read and 0 for a write, and bits 6:0 hold the byte count minus one.
- R2: The control byte is followed by 0xD4, then address bits 15:8, then address bits 7:0. These four bytes form the header.
- R3: A count of 0, or a count above MAX_LEN (128), ends with status 1 (bad parameter). Chip select never falls and no SCLK edge occurs, and done pulses two cycles after acceptance.
- R4: When req_chunk is set, the request is always a read whatever req_write says. Only counts 1, 2 and 4 are legal, and any other count ends with status 1 and no bus activity.
- R5: If bit 0 of the byte received during the fourth header byte is 1, the data phase follows at once with no polling bytes.
- R6: If that bit is 0, the engine sends 0x00 polling bytes, each one alone, and stops polling after the first polling byte whose received bit 0 is 1.
- R7: After WAIT_RETRIES (50) polling bytes that all return bit 0 clear, the engine ends with status 2 (timeout) and has no data phase. A device that becomes ready on the 50th polling byte still gives success.
- R8: Chip select stays low without a break from the first header bit to the last bit of the transaction, poll bytes included. It is high in the cycle done pulses.
- R9: The data phase moves exactly the requested number of bytes. A write sends req_wdata bits [8k+7:8k] as byte k for k = 0, 1, and so on. A read sends 0x00 and stores received byte k in rdata bits [8k+7:8k]. Completion status is 0 (success).
- R10: SPI mode 0 is used. SCLK is low whenever no byte is being shifted, MOSI changes only while SCLK is low, MISO is sampled on the rising edge, and bits go most significant first.
- R11: A request is taken only when the engine is idle. busy is high from the cycle after acceptance until done pulses. A request held during busy is taken in the cycle done pulses, and busy is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read (ignored in chunk mode) |
| req_chunk | input | 1 | Short-read mode (1, 2 or 4 bytes) |
| req_addr | input | 16 | TPM register address |
| req_len | input | 8 | Byte count |
| req_wdata | input | MAX_LEN*8 | Write payload, byte k at bits [8k+7:8k] |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 success, 1 bad parameter, 2 timeout |
| rdata | output | MAX_LEN*8 | Read payload, byte k at bits [8k+7:8k] |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The completion pulse of one transaction and the acceptance of the next request can fall in the same cycle, because the engine is already idle while done is high. The bench provokes this by issuing requests back to back, so each new request is held on the inputs through the previous transaction. The bench checks that busy rises in the cycle right after done. It also checks that the held request was not taken early: the next chip-select window must carry exactly that request's header, polls and payload.

// File: rtl/tpm_spi_pkg.sv
package tpm_spi_pkg;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_BADPARAM = 2'd1,
    ST_TIMEOUT  = 2'd2
  } tpm_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_HDR,
    S_POLL,
    S_DATA,
    S_CLOSE
  } seq_state_e;

  localparam logic [7:0] ADDR_PREFIX = 8'hD4;

  // direction flag on top, count-minus-one below it
  function automatic logic [7:0] ctrl_byte(input logic is_write, input logic [7:0] len);
    logic [7:0] lm1;
    lm1 = len - 8'd1;
    return {~is_write, lm1[6:0]};
  endfunction

  function automatic logic len_legal(input logic chunk, input logic [7:0] len,
                                     input int unsigned max_len);
    if (chunk) return (len == 8'd1) || (len == 8'd2) || (len == 8'd4);
    return (len != 8'd0) && (32'(len) <= max_len);
  endfunction

  function automatic logic [7:0] hdr_pick(input logic [1:0] sel, input logic [7:0] ctrl,
                                          input logic [15:0] addr);
    case (sel)
      2'd0:    return ctrl;
      2'd1:    return ADDR_PREFIX;
      2'd2:    return addr[15:8];
      default: return addr[7:0];
    endcase
  endfunction

endpackage

// File: rtl/tpm_spi_tick.sv
module tpm_spi_tick #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = (HALF > 1) ? $clog2(HALF) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run)                cnt <= '0;
    else if (cnt == W'(HALF - 1)) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == W'(HALF - 1));
endmodule

// File: rtl/tpm_spi_byte.sv
module tpm_spi_byte (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       tick,
  input  logic       miso,
  output logic       active,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       byte_done
);
  logic [7:0] tx_sr, rx_sr;
  logic [2:0] bit_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0; rx_sr <= '0; bit_n <= '0;
      active <= 1'b0; sclk <= 1'b0; byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (start) begin
        tx_sr <= tx; bit_n <= '0; active <= 1'b1; sclk <= 1'b0;
      end else if (active && tick) begin
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sr <= {rx_sr[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_n == 3'd7) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
          end else begin
            tx_sr <= {tx_sr[6:0], 1'b0};
            bit_n <= bit_n + 3'd1;
          end
        end
      end
    end
  end

  assign mosi = tx_sr[7];
  assign rx   = rx_sr;

  // R10: data out must not move while the clock is high
  p_mosi_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
  // R10: clock parks low between bytes
  p_sclk_park_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sclk);
endmodule

// File: rtl/tpm_spi_seq.sv
module tpm_spi_seq
  import tpm_spi_pkg::*;
#(
  parameter int MAX_LEN      = 128,
  parameter int SCLK_HALF    = 2,
  parameter int WAIT_RETRIES = 50
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_chunk,
  input  logic [15:0]          req_addr,
  input  logic [7:0]           req_len,
  input  logic [MAX_LEN*8-1:0] req_wdata,
  output logic                 busy,
  output logic                 done,
  output logic [1:0]           status,
  output logic [MAX_LEN*8-1:0] rdata,
  output logic                 spi_sclk,
  output logic                 spi_cs_n,
  output logic                 spi_mosi,
  input  logic                 spi_miso
);
  localparam int DW = MAX_LEN * 8;
  localparam int PW = $clog2(WAIT_RETRIES + 1);

  seq_state_e   state;
  tpm_status_e  status_q;
  logic         cs_n_q, done_q, start_q, wr_q;
  logic [7:0]   len_q, idx, tx_q;
  logic [15:0]  addr_q;
  logic [PW-1:0] polls;
  logic [DW-1:0] wbuf, rbuf;

  logic tick, sh_active, byte_done;
  logic [7:0] rx;

  // named events for the checks below
  logic accept, req_ok, hdr_last, wait_over, data_last;
  logic [7:0] nidx;
  assign accept    = (state == S_IDLE) && req_valid;
  assign req_ok    = len_legal(req_chunk, req_len, MAX_LEN);
  assign hdr_last  = (state == S_HDR) && (idx == 8'd3);
  assign wait_over = byte_done && rx[0] && (hdr_last || state == S_POLL);
  assign data_last = byte_done && (state == S_DATA) && (idx == len_q - 8'd1);
  assign nidx      = idx + 8'd1;

  tpm_spi_tick #(.HALF(SCLK_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(sh_active), .tick(tick));

  tpm_spi_byte u_byte (
    .clk(clk), .rst_n(rst_n), .start(start_q), .tx(tx_q), .tick(tick),
    .miso(spi_miso), .active(sh_active), .sclk(spi_sclk), .mosi(spi_mosi),
    .rx(rx), .byte_done(byte_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; status_q <= ST_OK; cs_n_q <= 1'b1; done_q <= 1'b0;
      start_q <= 1'b0; wr_q <= 1'b0; len_q <= '0; idx <= '0; tx_q <= '0;
      addr_q <= '0; polls <= '0; wbuf <= '0; rbuf <= '0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          wr_q   <= req_write & ~req_chunk;
          len_q  <= req_len;
          addr_q <= req_addr;
          wbuf   <= req_wdata;
          idx    <= '0;
          polls  <= '0;
          if (req_ok) begin
            cs_n_q  <= 1'b0;
            state   <= S_HDR;
            tx_q    <= ctrl_byte(req_write & ~req_chunk, req_len);
            start_q <= 1'b1;
          end else begin
            status_q <= ST_BADPARAM;
            state    <= S_CLOSE;
          end
        end
        S_HDR: if (byte_done) begin
          if (hdr_last) begin
            if (rx[0]) begin
              state <= S_DATA; idx <= '0;
              tx_q  <= wr_q ? wbuf[7:0] : 8'h00;
            end else begin
              state <= S_POLL; tx_q <= 8'h00;
            end
          end else begin
            idx  <= nidx;
            tx_q <= hdr_pick(nidx[1:0], ctrl_byte(wr_q, len_q), addr_q);
          end
          start_q <= 1'b1;
        end
        S_POLL: if (byte_done) begin
          if (rx[0]) begin
            state <= S_DATA; idx <= '0;
            tx_q  <= wr_q ? wbuf[7:0] : 8'h00;
            start_q <= 1'b1;
          end else if (polls == PW'(WAIT_RETRIES - 1)) begin
            status_q <= ST_TIMEOUT; cs_n_q <= 1'b1; state <= S_CLOSE;
          end else begin
            polls <= polls + 1'b1; tx_q <= 8'h00; start_q <= 1'b1;
          end
        end
        S_DATA: if (byte_done) begin
          if (!wr_q) rbuf[{idx, 3'b000} +: 8] <= rx;
          if (data_last) begin
            status_q <= ST_OK; cs_n_q <= 1'b1; state <= S_CLOSE;
          end else begin
            idx     <= nidx;
            tx_q    <= wr_q ? wbuf[{nidx, 3'b000} +: 8] : 8'h00;
            start_q <= 1'b1;
          end
        end
        S_CLOSE: begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign done     = done_q;
  assign status   = status_q;
  assign rdata    = rbuf;
  assign spi_cs_n = cs_n_q;

  // R8: the select line is already released when completion is reported
  p_cs_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> spi_cs_n);
  // R8: no serial clock activity outside a select window
  p_sclk_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  // R3: a refused request never touches the bus
  p_bad_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == ST_BADPARAM) |-> ($past(spi_cs_n, 1) && $past(spi_cs_n, 2)));
  // R7: polling never exceeds the retry budget
  p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POLL) |-> (polls < PW'(WAIT_RETRIES)));
  // R5/R6: a ready flag always leads straight into the data phase
  p_wait_over_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_over |=> (state == S_DATA && !spi_cs_n));
  // R11: completion is never reported while still busy
  p_busy_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/tpm_spi_seq_tb_top.sv
module tpm_spi_seq_tb_top;
  localparam int MAX_LEN = 128;
  localparam int DW      = MAX_LEN * 8;
  localparam int RETRIES = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_write = 1'b0, req_chunk = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic [DW-1:0] req_wdata = '0;
  logic busy, done, sclk, cs_n, mosi, miso;
  logic [1:0] status;
  logic [DW-1:0] rdata;

  tpm_spi_seq #(.MAX_LEN(MAX_LEN), .SCLK_HALF(2), .WAIT_RETRIES(RETRIES)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_chunk(req_chunk), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .busy(busy), .done(done), .status(status),
    .rdata(rdata), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso));

  typedef struct {
    logic [1:0]    st;
    int            nb;
    int            npoll;
    int            rd_n;
    logic [1535:0] mo;
    logic [DW-1:0] rd;
  } exp_t;

  exp_t          exp_q[$];
  logic [1535:0] mi_q[$];
  int checks = 0, fails = 0;
  bit wd = 1'b0;

  // ---------------- device model ----------------
  int bitc = 0, nby = 0, sess_cnt = 0, sess_n = 0;
  logic [7:0] got [0:255];
  logic [7:0] rxb = '0, mi_sr = '0;
  logic [1535:0] cur_mi = '0;
  assign miso = mi_sr[7];

  always @(posedge sclk or posedge cs_n) begin
    if (cs_n === 1'b1) begin
      if (nby != 0 || bitc != 0) begin sess_n = nby; sess_cnt++; end
      bitc = 0; nby = 0;
    end else begin
      rxb = {rxb[6:0], mosi};
      bitc++;
      if (bitc == 8) begin
        if (nby < 256) got[nby] = rxb;
        nby++; bitc = 0;
      end
    end
  end

  always @(negedge sclk or negedge cs_n) begin
    if (cs_n === 1'b0) begin
      if (bitc == 0 && nby == 0) begin
        if (mi_q.size() != 0) cur_mi = mi_q.pop_front();
        mi_sr = cur_mi[7:0];
      end else if (bitc == 0) begin
        mi_sr = (nby < 192) ? cur_mi[nby*8 +: 8] : 8'h00;
      end else begin
        mi_sr = {mi_sr[6:0], 1'b0};
      end
    end
  end

  // ---------------- scoreboard monitor ----------------
  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  initial begin
    exp_t  e;
    string tag;
    int    mon_seen;
    bit    chk_acc;
    mon_seen = 0; chk_acc = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0 && done === 1'b0,
        "R8/R10 reset idle", {60'd0, cs_n, sclk, busy, done}, 64'h8);
    forever begin
      @(negedge clk);
      if (chk_acc) begin
        chk(busy === 1'b1, "R11 taken in done cycle", 64'(busy), 64'd1);
        chk_acc = 1'b0;
      end
      if (done === 1'b1) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected done", 64'd1, 64'd0);
        end else begin
          e = exp_q.pop_front();
          tag = (e.st == 2'd1) ? "R3/R4 status" : (e.st == 2'd2) ? "R7 status" : "R9 status";
          chk(status === e.st, tag, 64'(status), 64'(e.st));
          chk(cs_n === 1'b1, "R8 cs high at done", 64'(cs_n), 64'd1);
          if (e.nb == 0) begin
            chk(sess_cnt == mon_seen, "R3 no bus activity", 64'(sess_cnt - mon_seen), 64'd0);
          end else begin
            chk(sess_cnt == mon_seen + 1 && sess_n == e.nb, "R8 single select window byte count",
                64'(sess_n), 64'(e.nb));
            for (int k = 0; k < e.nb && k < sess_n; k++) begin
              tag = (k == 0) ? "R1 control byte" : (k < 4) ? "R2 header byte" :
                    (k < 4 + e.npoll) ? "R6 poll byte" : "R9 data byte";
              chk(got[k] === e.mo[k*8 +: 8], tag, 64'(got[k]), 64'(e.mo[k*8 +: 8]));
            end
          end
          mon_seen = sess_cnt;
          for (int k = 0; k < e.rd_n; k++)
            chk(rdata[k*8 +: 8] === e.rd[k*8 +: 8], "R9 read byte",
                64'(rdata[k*8 +: 8]), 64'(e.rd[k*8 +: 8]));
          if (req_valid === 1'b1) chk_acc = 1'b1;
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic do_req(input bit w, input bit ch, input logic [15:0] a,
                        input logic [7:0] ln, input int polls, input int seed);
    exp_t e;
    logic [1535:0] mi;
    logic [DW-1:0] wv;
    bit ok, weff;
    int np, p;
    ok   = ch ? (ln == 8'd1 || ln == 8'd2 || ln == 8'd4) : (ln >= 8'd1 && int'(ln) <= MAX_LEN);
    weff = w && !ch;
    e.st = 2'd0; e.nb = 0; e.npoll = 0; e.rd_n = 0; e.mo = '0; e.rd = '0;
    mi = '0; wv = '0;
    for (int k = 0; k < MAX_LEN; k++) wv[k*8 +: 8] = 8'(seed * 7 + k * 13 + 1);
    if (!ok) begin
      e.st = 2'd1;
    end else begin
      e.mo[7:0]   = (weff ? 8'h00 : 8'h80) | 8'(int'(ln) - 1);
      e.mo[15:8]  = 8'hD4;
      e.mo[23:16] = a[15:8];
      e.mo[31:24] = a[7:0];
      mi[23:0]    = 24'hFFFFFF;          // bit 0 set early must not count
      mi[31:24]   = (polls == 0) ? 8'h81 : 8'hFE;
      np = (polls > RETRIES) ? RETRIES : polls;
      e.npoll = np;
      for (int k = 0; k < np; k++) mi[(4+k)*8 +: 8] = (k == polls - 1) ? 8'h01 : 8'hFE;
      p = 4 + np;
      if (polls > RETRIES) begin
        e.st = 2'd2; e.nb = p;
      end else begin
        for (int k = 0; k < int'(ln); k++) begin
          if (weff) begin
            e.mo[(p+k)*8 +: 8] = wv[k*8 +: 8];
            mi[(p+k)*8 +: 8]   = 8'hA5;
          end else begin
            mi[(p+k)*8 +: 8]   = 8'(seed * 11 + k * 5 + 3);
            e.rd[k*8 +: 8]     = 8'(seed * 11 + k * 5 + 3);
          end
        end
        if (!weff) e.rd_n = int'(ln);
        e.nb = p + int'(ln);
      end
    end
    @(negedge clk);
    req_write = w; req_chunk = ch; req_addr = a; req_len = ln; req_wdata = wv;
    req_valid = 1'b1;
    while (busy === 1'b1) @(negedge clk);
    exp_q.push_back(e);
    if (ok) mi_q.push_back(mi);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy === 1'b1 || exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        do_req(1, 0, 16'h0F00, 8'd1, 0, 1);    wait_idle(); // R1 R2 R5 R9 write, no wait
        do_req(0, 1, 16'h0024, 8'd4, 3, 2);    wait_idle(); // R4 R6 chunk read with polls
        do_req(1, 0, 16'hF000, 8'd128, 0, 3);  wait_idle(); // R1 max length
        do_req(0, 0, 16'h0018, 8'd0, 0, 4);    wait_idle(); // R3 zero length
        do_req(1, 0, 16'h0018, 8'd129, 0, 5);  wait_idle(); // R3 over limit
        do_req(0, 1, 16'h0018, 8'd3, 0, 6);    wait_idle(); // R4 illegal chunk
        do_req(1, 1, 16'h0030, 8'd2, 1, 7);    wait_idle(); // R4 chunk forces read
        do_req(0, 0, 16'h0014, 8'd5, 50, 8);   wait_idle(); // R7 ready on last poll
        do_req(0, 0, 16'h0014, 8'd5, 51, 9);   wait_idle(); // R7 timeout
        do_req(0, 0, 16'h1234, 8'd2, 2, 10);                // R11 back to back
        do_req(1, 0, 16'h5678, 8'd3, 0, 11);
        do_req(0, 1, 16'h0001, 8'd4, 1, 12);
        do_req(0, 0, 16'h0002, 8'd0, 0, 13);
        do_req(1, 0, 16'h00AA, 8'd16, 4, 14);
        wait_idle();
      end
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + int'(wd), fails + int'(wd));
    $finish;
  end
endmodule